// File: doc/BRIEF.md
# Transmit Link Phase Sequencer

This block steps one transmit lane of a serial converter link through its three phases. In the comma phase, the lane repeats a comma character while the receiver re-acquires character lock. In the alignment phase, an external generator produces the lane alignment multiframes. In the user phase, sample octets pass through. A registered phase code drives an octet selector. That selector puts the comma symbol, the alignment generator's symbol or the user octet on the lane output.

The receiver requests resynchronisation by holding an active-low request line low. Once the request is released, the sequencer leaves the comma phase only at a boundary. In subclass 0 this is a frame boundary. In any other subclass it is a multiframe boundary. Both boundary strobes are expected in the last octet cycle before the boundary, so the first octet of the new phase falls exactly on the boundary. Alignment can be switched off, and the sequencer then goes straight to user data. When the alignment phase starts, the sequencer gives the generator a one-cycle start pulse and a multiframe total. It then waits for the generator's done flag. Pulling the request low in a later phase returns the lane to commas on the next cycle.

Top module: `jtx_link_seq`

## Requirements
- R1: A synchronous reset puts the block in the comma phase (`phase` = 0), with `align_start` low and the lane carrying the comma symbol.
- R2: While `phase` is 0, `lane_sel` is 0, `lane_data` is 8'hBC and `lane_k` is 1.
- R3: With `cfg_subclass` = 0, the comma phase ends only after a clock edge where `sync_req_n` is 1 and `frame_edge` is 1, and the new phase shows on the next cycle. `mf_edge` has no effect in this subclass.
- R4: With a nonzero `cfg_subclass`, the comma phase ends only after the first clock edge where `sync_req_n` is 1 and `mf_edge` is 1. `frame_edge` has no effect in these subclasses.
- R5: While `sync_req_n` is 0, the comma phase is held, whatever the boundary strobes do.
- R6: On leaving the comma phase, the block enters the alignment phase (`phase` = 1) if `cfg_align_en` is 1. It enters the user phase (`phase` = 2) with no start pulse if `cfg_align_en` is 0.
- R7: `align_start` is high for exactly the first cycle of each alignment phase and low at all other times.
- R8: `align_mf_total` equals `cfg_align_len` + 1 (1 to 256) when `cfg_subclass` is 0, and equals 4 otherwise.
- R9: In the alignment phase, an edge with `align_done` high and `sync_req_n` high moves the block to the user phase on the next cycle. Without `align_done`, the block stays in the alignment phase.
- R10: An edge with `sync_req_n` low in the alignment or user phase returns the block to the comma phase on the next cycle. This takes priority over `align_done`.
- R11: In the alignment phase, `lane_sel` is 1 and the lane carries `align_octet`/`align_k`. In the user phase, `lane_sel` is 2 and the lane carries `user_octet` with `lane_k` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane octet clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_req_n | input | 1 | Active-low resynchronisation request from the receiver |
| frame_edge | input | 1 | High in the last octet cycle of a frame |
| mf_edge | input | 1 | High in the last octet cycle of a multiframe |
| cfg_subclass | input | 2 | Deterministic-latency subclass; 0 selects frame-boundary exit |
| cfg_align_en | input | 1 | Enables the alignment phase |
| cfg_align_len | input | 8 | Alignment multiframes minus one, used in subclass 0 |
| align_done | input | 1 | Alignment generator has sent its last multiframe |
| align_octet | input | 8 | Octet from the alignment generator |
| align_k | input | 1 | Control flag of the alignment octet |
| user_octet | input | 8 | User data octet |
| phase | output | 2 | 0 comma, 1 alignment, 2 user |
| lane_sel | output | 2 | Octet source: 0 comma, 1 alignment, 2 user |
| align_start | output | 1 | One-cycle start pulse for the alignment generator |
| align_mf_total | output | 9 | Multiframes the generator must send |
| lane_data | output | 8 | Selected lane octet |
| lane_k | output | 1 | Control flag of the selected octet |

## Verification
The bound checker checks several properties on every cycle: that the comma phase holds while the request is low or the boundary strobe for the subclass is absent, the comma symbol on the lane, the single-cycle start pulse and its tie to the comma-to-alignment step, the one-cycle return to commas on a request, and the fixed length outside subclass 0. Only the bench scenarios can show certain end-to-end behaviour. This covers the exit landing on the first qualifying boundary after release, for every release offset within a multiframe. It also covers the alignment phase lasting exactly until the done flag, the pass-through of changing alignment and user octets, and a request taking priority over a done flag in the same cycle.

// File: rtl/jtx_seq_pkg.sv
package jtx_seq_pkg;

    localparam int OCTET_W = 8;
    localparam logic [OCTET_W-1:0] COMMA_OCTET = 8'hBC;

    typedef enum logic [1:0] {
        PH_COMMA = 2'd0,
        PH_ALIGN = 2'd1,
        PH_USER  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        SEL_COMMA = 2'd0,
        SEL_ALIGN = 2'd1,
        SEL_USER  = 2'd2
    } sel_e;

    typedef struct packed {
        logic [OCTET_W-1:0] data;
        logic               k;
    } lane_sym_t;

    function automatic sel_e phase_to_sel(input phase_e p);
        case (p)
            PH_ALIGN: return SEL_ALIGN;
            PH_USER:  return SEL_USER;
            default:  return SEL_COMMA;
        endcase
    endfunction

endpackage

// File: rtl/jtx_exit_gate.sv
module jtx_exit_gate #(
    parameter int SC_W = 2
) (
    input  logic            sync_req_n,
    input  logic            frame_edge,
    input  logic            mf_edge,
    input  logic [SC_W-1:0] cfg_subclass,
    output logic            exit_ok
);
    logic boundary;

    always_comb begin
        if (cfg_subclass == '0) boundary = frame_edge;
        else                    boundary = mf_edge;
        exit_ok = sync_req_n & boundary;
    end
endmodule

// File: rtl/jtx_align_len.sv
module jtx_align_len #(
    parameter int SC_W     = 2,
    parameter int LEN_W    = 8,
    parameter int FIXED_MF = 4
) (
    input  logic [SC_W-1:0]  cfg_subclass,
    input  logic [LEN_W-1:0] cfg_align_len,
    output logic [LEN_W:0]   mf_total
);
    localparam logic [LEN_W:0] FIXED_TOTAL = (LEN_W+1)'(FIXED_MF);
    localparam logic [LEN_W:0] ONE         = (LEN_W+1)'(1);

    always_comb begin
        if (cfg_subclass == '0) mf_total = {1'b0, cfg_align_len} + ONE;
        else                    mf_total = FIXED_TOTAL;
    end
endmodule

// File: rtl/jtx_phase_fsm.sv
module jtx_phase_fsm
    import jtx_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_req_n,
    input  logic   exit_ok,
    input  logic   cfg_align_en,
    input  logic   align_done,
    output phase_e phase_q,
    output logic   start_q
);
    phase_e phase_d;

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_COMMA: if (exit_ok) phase_d = cfg_align_en ? PH_ALIGN : PH_USER;
            PH_ALIGN: begin
                if (!sync_req_n)     phase_d = PH_COMMA;
                else if (align_done) phase_d = PH_USER;
            end
            PH_USER:  if (!sync_req_n) phase_d = PH_COMMA;
            default:  phase_d = PH_COMMA;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_COMMA;
            start_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            start_q <= (phase_q == PH_COMMA) && (phase_d == PH_ALIGN);
        end
    end
endmodule

// File: rtl/jtx_lane_mux.sv
module jtx_lane_mux
    import jtx_seq_pkg::*;
(
    input  sel_e               sel,
    input  logic [OCTET_W-1:0] align_octet,
    input  logic               align_k,
    input  logic [OCTET_W-1:0] user_octet,
    output lane_sym_t          sym
);
    always_comb begin
        case (sel)
            SEL_ALIGN: sym = '{data: align_octet, k: align_k};
            SEL_USER:  sym = '{data: user_octet,  k: 1'b0};
            default:   sym = '{data: COMMA_OCTET, k: 1'b1};
        endcase
    end
endmodule

// File: rtl/jtx_link_seq.sv
module jtx_link_seq
    import jtx_seq_pkg::*;
#(
    parameter int SC_W     = 2,
    parameter int LEN_W    = 8,
    parameter int FIXED_MF = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_req_n,
    input  logic             frame_edge,
    input  logic             mf_edge,
    input  logic [SC_W-1:0]  cfg_subclass,
    input  logic             cfg_align_en,
    input  logic [LEN_W-1:0] cfg_align_len,
    input  logic             align_done,
    input  logic [7:0]       align_octet,
    input  logic             align_k,
    input  logic [7:0]       user_octet,
    output logic [1:0]       phase,
    output logic [1:0]       lane_sel,
    output logic             align_start,
    output logic [LEN_W:0]   align_mf_total,
    output logic [7:0]       lane_data,
    output logic             lane_k
);
    logic      exit_ok;
    phase_e    phase_q;
    sel_e      sel;
    lane_sym_t sym;

    jtx_exit_gate #(.SC_W(SC_W)) u_gate (
        .sync_req_n   (sync_req_n),
        .frame_edge   (frame_edge),
        .mf_edge      (mf_edge),
        .cfg_subclass (cfg_subclass),
        .exit_ok      (exit_ok)
    );

    jtx_align_len #(.SC_W(SC_W), .LEN_W(LEN_W), .FIXED_MF(FIXED_MF)) u_len (
        .cfg_subclass  (cfg_subclass),
        .cfg_align_len (cfg_align_len),
        .mf_total      (align_mf_total)
    );

    jtx_phase_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sync_req_n   (sync_req_n),
        .exit_ok      (exit_ok),
        .cfg_align_en (cfg_align_en),
        .align_done   (align_done),
        .phase_q      (phase_q),
        .start_q      (align_start)
    );

    assign sel = phase_to_sel(phase_q);

    jtx_lane_mux u_mux (
        .sel         (sel),
        .align_octet (align_octet),
        .align_k     (align_k),
        .user_octet  (user_octet),
        .sym         (sym)
    );

    assign phase     = phase_q;
    assign lane_sel  = sel;
    assign lane_data = sym.data;
    assign lane_k    = sym.k;
endmodule

// File: rtl/jtx_link_seq_chk.sv
module jtx_link_seq_chk #(
    parameter int SC_W  = 2,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_req_n,
    input logic             frame_edge,
    input logic             mf_edge,
    input logic [SC_W-1:0]  cfg_subclass,
    input logic             cfg_align_en,
    input logic [1:0]       phase,
    input logic             align_start,
    input logic [LEN_W:0]   align_mf_total,
    input logic [7:0]       lane_data,
    input logic             lane_k
);
    AST_COMMA_LANE: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd0 |-> (lane_data == 8'hBC && lane_k)); // R2

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && !sync_req_n) |=> phase == 2'd0); // R5

    AST_SC0_FRAME: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && cfg_subclass == '0 && !frame_edge) |=> phase == 2'd0); // R3

    AST_SCN_MF: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && cfg_subclass != '0 && !mf_edge) |=> phase == 2'd0); // R4

    AST_SKIP_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && $past(phase) == 2'd0) |-> !$past(cfg_align_en)); // R6

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        align_start |=> !align_start); // R7

    AST_START_ENTRY: assert property (@(posedge clk) disable iff (rst)
        align_start |-> (phase == 2'd1 && $past(phase) == 2'd0)); // R7

    AST_FIXED_LEN: assert property (@(posedge clk) disable iff (rst)
        cfg_subclass != '0 |-> align_mf_total == (LEN_W+1)'(4)); // R8

    AST_RESYNC: assert property (@(posedge clk) disable iff (rst)
        (phase != 2'd0 && !sync_req_n) |=> phase == 2'd0); // R10

    AST_USER_NOK: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd2 |-> !lane_k); // R11
endmodule

bind jtx_link_seq jtx_link_seq_chk #(.SC_W(SC_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/jtx_link_seq_tb.sv
module jtx_link_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_req_n = 1'b0;
    logic       frame_edge = 1'b0;
    logic       mf_edge = 1'b0;
    logic [1:0] cfg_subclass = 2'd0;
    logic       cfg_align_en = 1'b0;
    logic [7:0] cfg_align_len = 8'd0;
    logic       align_done = 1'b0;
    logic [7:0] align_octet = 8'd0;
    logic       align_k = 1'b0;
    logic [7:0] user_octet = 8'd0;
    logic [1:0] phase;
    logic [1:0] lane_sel;
    logic       align_start;
    logic [8:0] align_mf_total;
    logic [7:0] lane_data;
    logic       lane_k;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    jtx_link_seq u_dut (
        .clk(clk), .rst(rst), .sync_req_n(sync_req_n), .frame_edge(frame_edge),
        .mf_edge(mf_edge), .cfg_subclass(cfg_subclass), .cfg_align_en(cfg_align_en),
        .cfg_align_len(cfg_align_len), .align_done(align_done), .align_octet(align_octet),
        .align_k(align_k), .user_octet(user_octet), .phase(phase), .lane_sel(lane_sel),
        .align_start(align_start), .align_mf_total(align_mf_total),
        .lane_data(lane_data), .lane_k(lane_k)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic scenario(input int sc, input bit en, input int rel);
        int exit_t, done_t, data_t, rs_t, end_t, lat;
        bit pri;
        int exp_ph;
        string ph_req;
        lat = 1 + (rel % 3);
        pri = en && (rel % 2 == 1);
        exit_t = rel;
        while (!((sc == 0) ? (exit_t % 4 == 3) : (exit_t % 16 == 15))) exit_t++;
        done_t = exit_t + 1 + lat;
        data_t = en ? done_t + 1 : exit_t + 1;
        rs_t   = pri ? done_t : data_t + 3;
        end_t  = rs_t + 3;

        @(negedge clk);
        rst = 1'b1; sync_req_n = 1'b0; frame_edge = 1'b0; mf_edge = 1'b0; align_done = 1'b0;
        cfg_subclass = 2'(sc); cfg_align_en = en; cfg_align_len = 8'((rel * 17) % 256);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "reset phase", int'(phase), 0);
        chk("R1", "reset start", int'(align_start), 0);
        chk("R1", "reset lane", int'(lane_data), 'hBC);
        chk("R8", "mf total", int'(align_mf_total),
            (sc == 0) ? ((rel * 17) % 256) + 1 : 4);

        for (int t = 0; t <= end_t; t++) begin
            @(negedge clk);
            frame_edge  = (t % 4 == 3);
            mf_edge     = (t % 16 == 15);
            sync_req_n  = (t >= rel) && !(t >= rs_t);
            align_done  = en && (t == done_t);
            align_octet = 8'(t * 7);
            align_k     = t[0];
            user_octet  = ~8'(t);
            #1;
            if (t <= exit_t || t > rs_t) exp_ph = 0;
            else if (en && t < data_t) exp_ph = 1;
            else exp_ph = 2;
            if (t <= exit_t) ph_req = (t <= rel) ? "R5" : ((sc == 0) ? "R3" : "R4");
            else if (t > rs_t) ph_req = "R10";
            else if (t == exit_t + 1) ph_req = "R6";
            else ph_req = "R9";
            chk(ph_req, "phase", int'(phase), exp_ph);
            chk("R7", "start pulse", int'(align_start), (en && t == exit_t + 1) ? 1 : 0);
            if (exp_ph == 0) begin
                chk("R2", "comma sel", int'(lane_sel), 0);
                chk("R2", "comma octet", int'(lane_data), 'hBC);
                chk("R2", "comma k", int'(lane_k), 1);
            end else if (exp_ph == 1) begin
                chk("R11", "align sel", int'(lane_sel), 1);
                chk("R11", "align octet", int'(lane_data), (t * 7) % 256);
                chk("R11", "align k", int'(lane_k), t % 2);
            end else begin
                chk("R11", "user sel", int'(lane_sel), 2);
                chk("R11", "user octet", int'(lane_data), 255 - (t % 256));
                chk("R11", "user k", int'(lane_k), 0);
            end
        end
    endtask

    initial begin
        for (int sc = 0; sc < 4; sc++)
            for (int en = 0; en < 2; en++)
                for (int rel = 0; rel < 16; rel++)
                    scenario(sc, en[0], rel);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule